// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This peripheral holds four independent down-counters behind a simple word-addressed register interface. Each channel has a load register, a read-only view of its current count, a control register and a background reload register. A channel counts one step down on every prescaled tick. It runs in one of three modes: free-running, periodic or one-shot. Its width can be 16 or 32 bits, and its tick rate can be the bus clock divided by 1, 16 or 256.

A shared interrupt section records one raw status bit per channel. It also holds a mask, shows the masked status and accepts write-one-to-clear. The masked bits are ORed into a single interrupt line. Software reads the count and converts it to an up-count by inverting or negating it. A write to the background reload register changes the next period without disturbing the current one.

Each channel is controlled by a three-state machine:
- `CH_IDLE`: the channel is disabled.
- `CH_COUNT`: the channel is enabled and ticking.
- `CH_DONE`: a one-shot channel has expired and holds at zero.

The machine takes these transitions:
- `CH_IDLE` → `CH_COUNT` when the enable bit is set.
- `CH_COUNT` → `CH_IDLE` when the enable bit is cleared.
- `CH_COUNT` → `CH_DONE` on an underflow in one-shot mode.
- `CH_DONE` → `CH_IDLE` when the enable bit is cleared.
- `CH_DONE` → `CH_COUNT` on a write to the load register.

A channel ticks while its enable bit is set and it is not in `CH_DONE`.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Address map. Shared registers are word-aligned: 0x00 is the mask, 0x04 the raw status, 0x08 the masked status and 0x0C the clear register. In each of them, bit n is channel n. Channel n uses base 0x10+0x10·n with four registers:
  - +0x0: load value.
  - +0x4: current count, read-only; writes to it are ignored.
  - +0x8: control. Bit 7 is enable, bit 6 is periodic, bits 3:2 select the prescaler, bit 1 selects 32-bit width and bit 0 selects one-shot. Bits 5:4 and bits 31:8 read zero.
  - +0xC: background reload.
  Unmapped or unaligned addresses read zero, and writes to them do nothing.
- R3: An enabled channel decrements by one on each tick. The first tick at divide-by-1 comes on the first clock edge after the edge that writes the enable. A disabled channel holds its count.
- R4: Prescaler codes 00, 01, 10 and 11 give one tick every 1, 16, 256 and 256 enabled cycles. The phase restarts while the channel is not ticking and on a load write.
- R5: A load write sets the count, the load register and the reload value to the written word on that edge. It restarts the prescaler phase and moves a channel in `CH_DONE` back to `CH_COUNT`.
- R6: A write to the background reload register leaves the current count unchanged. The new value is used at the next periodic underflow.
- R7: A tick that arrives while the count (within the selected width) is zero is an underflow. It sets the channel's raw status bit, and periodic mode then loads the reload value.
- R8: Free-running mode (bit 6 and bit 0 both clear) wraps on underflow to all ones of the selected width.
- R9: One-shot mode holds at zero after its underflow and raises no further events until a load write or a disable.
- R10: With bit 1 clear, only the low 16 bits count and wrap, and the upper 16 bits of the count read zero.
- R11: `irq_out` is high exactly when some raw status bit and its mask bit are both set. A write to 0x00 replaces the mask.
- R12: Writing 1 to bit n of 0x0C clears raw bit n, but an underflow of channel n in the same cycle keeps the bit set. Raw bits stay set otherwise.
- R13: When bit 0 is set, one-shot behaviour applies whatever bit 6 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A reference model in the bench tracks every channel from the same bus writes, and the read data and interrupt are compared on every clock.

The counting is tried with these patterns, and each separates a different thing:
- A short free-running count through zero separates wrapping from reloading.
- A periodic channel whose reload value is rewritten mid-period shows whether the write disturbed the live count.
- A one-shot channel with the periodic bit also set shows mode precedence and holding at zero.
- A 16-bit channel loaded with a word that has upper bits set separates narrow from wide wrapping.
- Switching the prescaler across all four codes, with a reload restart, separates tick rates and phase handling.
- A reload value of zero gives an underflow on every tick, which exercises a clear that collides with a new event.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_DONE  = 2'd2
    } chan_state_e;

    // Control word, field positions are software visible
    typedef struct packed {
        logic       en;        // bit 7
        logic       periodic;  // bit 6
        logic [1:0] rsvd;      // bits 5:4, always zero
        logic [1:0] psel;      // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } ctrl_t;

    localparam logic [7:0] CTRL_KEEP = 8'hCF;

endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler #(
    parameter int PW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] psel,
    output logic       tick
);
    logic [PW-1:0] phase_q;
    logic [1:0]    code_eff;
    logic [PW-1:0] limit;

    // code 3 is reserved and behaves like code 2
    assign code_eff = (psel == 2'd3) ? 2'd2 : psel;
    assign limit    = PW'((1 << (4 * code_eff)) - 1);
    assign tick     = run && !restart && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            phase_q <= '0;
        end else if (phase_q >= limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int PW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic              ctrl_we,
    input  logic              bg_we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] ld_q,
    output logic [DATA_W-1:0] bg_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] view_q,
    output logic              underflow
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    chan_state_e state_q, state_d;
    logic              run;
    logic              tick;
    logic [DATA_W-1:0] wmask;

    assign wmask     = ctrl_q.wide ? {DATA_W{1'b1}} : NARROW_MASK;
    assign view_q    = cnt_q & wmask;
    assign underflow = tick && (view_q == '0);

    qdt_prescaler #(.PW(PW)) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (ld_we),
        .psel    (ctrl_q.psel),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (ctrl_q.en) state_d = CH_COUNT;
            CH_COUNT: begin
                if (!ctrl_q.en)                         state_d = CH_IDLE;
                else if (underflow && ctrl_q.oneshot)   state_d = CH_DONE;
            end
            CH_DONE: begin
                if (!ctrl_q.en)  state_d = CH_IDLE;
                else if (ld_we)  state_d = CH_COUNT;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            CH_IDLE:  run = ctrl_q.en;
            CH_COUNT: run = ctrl_q.en;
            CH_DONE:  run = 1'b0;
            default:  run = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            bg_q   <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_t'(wdata[7:0] & CTRL_KEEP);
            if (ld_we || bg_we) bg_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q  <= '0;
            cnt_q <= '0;
        end else if (ld_we) begin
            ld_q  <= wdata;
            cnt_q <= wdata;
        end else if (tick) begin
            if (view_q != '0)          cnt_q <= view_q - 1'b1;
            else if (ctrl_q.oneshot)   cnt_q <= cnt_q;
            else if (ctrl_q.periodic)  cnt_q <= bg_q & wmask;
            else                       cnt_q <= wmask;
        end
    end
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] events,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;
    assign irq      = |(raw_q & mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | events;
            if (mask_we) mask_q <= wbits;
        end
    end
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12,
    parameter int NARROW_W = 16,
    parameter int PW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int RW = ADDR_W - 4;

    logic [RW-1:0] region;
    logic [1:0]    sub;
    logic          aligned;
    logic          shared_hit;

    logic [NUM_CH-1:0]             ch_hit;
    logic [NUM_CH-1:0]             events;
    logic [NUM_CH-1:0]             raw_q;
    logic [NUM_CH-1:0]             mask_q;
    ctrl_t [NUM_CH-1:0]            ctrl_q;
    logic [NUM_CH-1:0][DATA_W-1:0] ld_q;
    logic [NUM_CH-1:0][DATA_W-1:0] bg_q;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_q;
    logic [NUM_CH-1:0][DATA_W-1:0] view_q;

    assign region     = bus_addr[ADDR_W-1:4];
    assign sub        = bus_addr[3:2];
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign shared_hit = aligned && (region == '0);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign ch_hit[g] = aligned && (region == RW'(g + 1));
            qdt_channel #(
                .DATA_W   (DATA_W),
                .NARROW_W (NARROW_W),
                .PW       (PW)
            ) chan_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_we     (bus_wr && ch_hit[g] && (sub == 2'd0)),
                .ctrl_we   (bus_wr && ch_hit[g] && (sub == 2'd2)),
                .bg_we     (bus_wr && ch_hit[g] && (sub == 2'd3)),
                .wdata     (bus_wdata),
                .ctrl_q    (ctrl_q[g]),
                .ld_q      (ld_q[g]),
                .bg_q      (bg_q[g]),
                .cnt_q     (cnt_q[g]),
                .view_q    (view_q[g]),
                .underflow (events[g])
            );
        end
    endgenerate

    qdt_irq #(.NUM_CH(NUM_CH)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (events),
        .mask_we (bus_wr && shared_hit && (sub == 2'd0)),
        .clr_we  (bus_wr && shared_hit && (sub == 2'd3)),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq     (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (shared_hit) begin
            unique case (sub)
                2'd0: bus_rdata = DATA_W'(mask_q);
                2'd1: bus_rdata = DATA_W'(raw_q);
                2'd2: bus_rdata = DATA_W'(raw_q & mask_q);
                2'd3: bus_rdata = '0;
                default: bus_rdata = '0;
            endcase
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) begin
                unique case (sub)
                    2'd0: bus_rdata = ld_q[c];
                    2'd1: bus_rdata = view_q[c];
                    2'd2: bus_rdata = DATA_W'(ctrl_q[c]);
                    2'd3: bus_rdata = bg_q[c];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_wdata,
    input logic [DATA_W-1:0]                bus_rdata,
    input logic                             irq_out,
    input logic [NUM_CH-1:0]                raw_q,
    input logic [NUM_CH-1:0][DATA_W-1:0]    cnt_q
);
    localparam int RW = ADDR_W - 4;

    // R2: addresses above the last channel read zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:4] > RW'(NUM_CH)) |-> (bus_rdata == '0));

    // R11: clearing the whole mask silences the interrupt on the next cycle
    assert_mask_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[NUM_CH-1:0] == '0) |=> !irq_out);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R12: a raw bit stays set unless its clear bit is written
            assert_raw_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_q[i] && !(bus_wr && bus_addr == ADDR_W'(12) && bus_wdata[i]))
                |=> raw_q[i]);

            // R5: a load write places the word into the count on that edge
            assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr[ADDR_W-1:4] == RW'(i + 1) && bus_addr[3:0] == 4'd0)
                |=> (cnt_q[i] == $past(bus_wdata)));
        end
    endgenerate
endmodule

bind quad_down_timer qdt_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .raw_q     (raw_q),
    .cnt_q     (cnt_q)
);

// File: tb/quad_down_timer_tb_top.sv
module quad_down_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    quad_down_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // reference model state
    logic [31:0] m_cnt [4];
    logic [31:0] m_ld  [4];
    logic [31:0] m_bg  [4];
    logic [7:0]  m_ctrl[4];
    int          m_pre [4];
    bit          m_done[4];
    logic [3:0]  m_raw, m_mask;

    function automatic logic [31:0] mrd(input logic [11:0] a);
        int r;
        r = int'(a[11:4]);
        if (a[1:0] != 2'b00) return 32'h0;
        if (r == 0) begin
            case (a[3:2])
                2'd0: return {28'h0, m_mask};
                2'd1: return {28'h0, m_raw};
                2'd2: return {28'h0, m_raw & m_mask};
                default: return 32'h0;
            endcase
        end
        if (r >= 1 && r <= 4) begin
            case (a[3:2])
                2'd0: return m_ld[r-1];
                2'd1: return m_cnt[r-1] & (m_ctrl[r-1][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
                2'd2: return {24'h0, m_ctrl[r-1]};
                default: return m_bg[r-1];
            endcase
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_cnt[c] = 0; m_ld[c] = 0; m_bg[c] = 0; m_ctrl[c] = 0;
                m_pre[c] = 0; m_done[c] = 0;
            end
            m_raw = 0; m_mask = 0;
        end else begin
            logic [3:0]  ev;
            logic [3:0]  clr;
            logic [31:0] wm;
            int          lim;
            bit          al;
            int          reg_r;
            ev    = 0;
            al    = (bus_addr[1:0] == 2'b00);
            reg_r = int'(bus_addr[11:4]);
            for (int c = 0; c < 4; c++) begin
                bit hit;
                hit = bus_wr && al && (reg_r == c + 1);
                wm  = m_ctrl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                case (m_ctrl[c][3:2])
                    2'd0: lim = 0;
                    2'd1: lim = 15;
                    default: lim = 255;
                endcase
                if (hit && bus_addr[3:2] == 2'd0) begin
                    m_cnt[c] = bus_wdata; m_ld[c] = bus_wdata; m_bg[c] = bus_wdata;
                    m_pre[c] = 0; m_done[c] = 0;
                end else if (m_ctrl[c][7] && !m_done[c]) begin
                    if (m_pre[c] >= lim) begin
                        m_pre[c] = 0;
                        if ((m_cnt[c] & wm) == 0) begin
                            ev[c] = 1'b1;
                            if (m_ctrl[c][0])      m_done[c] = 1;
                            else if (m_ctrl[c][6]) m_cnt[c] = m_bg[c] & wm;
                            else                   m_cnt[c] = wm;
                        end else begin
                            m_cnt[c] = (m_cnt[c] & wm) - 1;
                        end
                    end else begin
                        m_pre[c] = m_pre[c] + 1;
                    end
                end else begin
                    m_pre[c] = 0;
                    if (!m_ctrl[c][7]) m_done[c] = 0;
                end
                if (hit && bus_addr[3:2] == 2'd2) m_ctrl[c] = bus_wdata[7:0] & 8'hCF;
                if (hit && bus_addr[3:2] == 2'd3) m_bg[c] = bus_wdata;
            end
            clr = (bus_wr && bus_addr == 12'h00C) ? bus_wdata[3:0] : 4'h0;
            m_raw = (m_raw & ~clr) | ev;
            if (bus_wr && bus_addr == 12'h000) m_mask = bus_wdata[3:0];
        end
    end

    // continuous comparison against the model
    always @(negedge clk) begin
        #3;
        if (rst_n && !finished) begin
            checks++;
            if (bus_rdata !== mrd(bus_addr)) begin
                fails++;
                $display("FAIL R2/R3 model read addr=%h got=%h exp=%h",
                         bus_addr, bus_rdata, mrd(bus_addr));
            end
            checks++;
            if (irq_out !== |(m_raw & m_mask)) begin
                fails++;
                $display("FAIL R11 model irq got=%b exp=%b", irq_out, |(m_raw & m_mask));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired got=%0d exp<=50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_m(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        checks++;
        if (bus_rdata !== mrd(a)) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, bus_rdata, mrd(a));
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        #2;
        checks++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s irq got=%b exp=%b", tag, irq_out, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(12'h014, 32'h0, "R1 count ch0");
        chk(12'h038, 32'h0, "R1 ctrl ch2");
        chk(12'h04C, 32'h0, "R1 reload ch3");
        chk(12'h004, 32'h0, "R1 raw");
        chk_irq(1'b0, "R1");

        // R2 map, reserved control bits, unmapped reads, read-only count
        wr(12'h038, 32'h0000_007F);
        chk(12'h038, 32'h0000_004F, "R2 ctrl reserved bits");
        wr(12'h038, 32'h0);
        chk(12'h050, 32'h0, "R2 unmapped");
        chk(12'h011, 32'h0, "R2 unaligned");
        wr(12'h014, 32'h1234);
        chk(12'h014, 32'h0, "R2 count write ignored");

        // R5 load, R3 counting, R8 free-running wrap, R7 status
        wr(12'h010, 32'd10);
        chk(12'h010, 32'd10, "R5 load reg");
        chk(12'h014, 32'd10, "R5 count loaded");
        wr(12'h018, 32'h82);
        chk(12'h014, 32'd9, "R3 first tick");
        chk(12'h014, 32'd8, "R3 second tick");
        idle(12);
        chk(12'h004, 32'h1, "R7 raw set on underflow");
        chk_m(12'h014, "R8 wrap to all ones");
        wr(12'h018, 32'h0);
        chk_m(12'h014, "R3 disabled holds");
        wr(12'h00C, 32'h1);
        chk(12'h004, 32'h0, "R12 clear");

        // R7 periodic, R6 background reload, R11 mask
        wr(12'h000, 32'h2);
        wr(12'h020, 32'd3);
        wr(12'h028, 32'hC2);
        idle(6);
        chk_m(12'h004, "R7 periodic status");
        chk_m(12'h024, "R7 periodic reload");
        wr(12'h02C, 32'd7);
        chk_m(12'h024, "R6 count undisturbed");
        idle(9);
        chk_m(12'h024, "R6 new period");
        chk_m(12'h008, "R11 masked status");
        wr(12'h000, 32'h0);
        chk_irq(1'b0, "R11 mask off");
        wr(12'h000, 32'h2);

        // R12 set wins over same-cycle clear
        wr(12'h02C, 32'd0);
        wr(12'h020, 32'd0);
        idle(2);
        wr(12'h00C, 32'h2);
        chk(12'h004, 32'h2, "R12 set wins");
        wr(12'h028, 32'h0);
        wr(12'h00C, 32'h2);
        chk(12'h004, 32'h0, "R12 cleared after stop");
        chk_irq(1'b0, "R11 irq low");

        // R9 one-shot, R13 precedence over periodic bit
        wr(12'h030, 32'd2);
        wr(12'h038, 32'hC3);
        idle(8);
        chk(12'h034, 32'h0, "R9 holds zero");
        chk(12'h004, 32'h4, "R9 single event");
        wr(12'h00C, 32'h4);
        idle(5);
        chk(12'h004, 32'h0, "R13 no periodic reload");
        chk(12'h034, 32'h0, "R9 still zero");
        wr(12'h030, 32'd2);
        chk_m(12'h034, "R9 rearm");
        idle(6);
        chk(12'h004, 32'h4, "R9 event after rearm");
        wr(12'h038, 32'h0);
        wr(12'h00C, 32'h4);

        // R10 narrow width
        wr(12'h040, 32'h1234_0002);
        chk(12'h044, 32'h2, "R10 upper bits hidden");
        wr(12'h048, 32'h80);
        chk(12'h044, 32'h1, "R10 tick");
        chk(12'h044, 32'h0, "R10 zero");
        chk(12'h044, 32'h0000_FFFF, "R10 narrow wrap");
        wr(12'h048, 32'h0);

        // R4 prescaler codes
        wr(12'h010, 32'd5);
        wr(12'h018, 32'h86);
        chk(12'h014, 32'd5, "R4 div16 no early tick");
        idle(40);
        chk_m(12'h014, "R4 div16");
        wr(12'h018, 32'h8A);
        idle(600);
        chk_m(12'h014, "R4 div256");
        wr(12'h018, 32'h8E);
        wr(12'h010, 32'd3);
        idle(300);
        chk_m(12'h014, "R4 code 11 and restart");
        chk_m(12'h004, "R4 status");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule